// File: doc/BRIEF.md
# Two-Wire Bus Slave with Programmable Address Match

This block is a slave on a two-wire serial bus (SCL clock, open-drain SDA data). It samples both lines through a short synchroniser and finds bus starts, stops and SCL edges. It shifts in the first byte after each start and compares that byte with a programmed 7-bit own address. One configuration input switches the compare to a partial mode, where only the four upper address bits must agree.

A matching address sets a flag and latches the transfer direction carried in the address byte's bit 0. The slave always acknowledges its own address. In a write transfer, each received byte is presented on a valid-only output stream, and the acknowledge slot is driven from a configuration bit. In a read transfer, the transmit data input is copied into the shifter on the address match, and again after every byte that the master acknowledges. The copy is signalled on a one-cycle pulse, so the producer can present the next byte. The receive stream has no ready input and the transmit side has no valid input. Because the slave never holds SCL low, it cannot apply back-pressure: a consumer must accept every `rx_valid` pulse, and the producer must keep `tx_data` stable from a `tx_taken` pulse until the next acknowledge slot ends.

Top module: `i2c_addr_slave`

## Requirements
- R1: SCL and SDA pass through two synchronising flip-flops. A START is an SDA fall while SCL is high, and a STOP is an SDA rise while SCL is high. After reset the slave releases SDA and reports no match.
- R2: In full mode (`partial_mode`=0), the address byte matches when its bits 7:1 equal `own_addr[6:0]`.
- R3: In partial mode (`partial_mode`=1), the address byte matches when its bits 7:4 equal `own_addr[6:3]`. Address bits 3:1 are then ignored.
- R4: On a match, `matched` goes to 1 and `slave_read` takes bit 0 of the address byte. A value of 1 means the master reads and 0 means the master writes.
- R5: The slave pulls SDA low in the acknowledge slot of a matching address byte. After a mismatch it drives nothing and delivers nothing until the next START.
- R6: In a write transfer, each 8-bit data byte (MSB first) appears on `rx_data` with a one-cycle `rx_valid` pulse.
- R7: In the acknowledge slot of a received data byte, the slave pulls SDA low when `nack_cfg`=0 and leaves SDA released when `nack_cfg`=1.
- R8: A matching read address copies `tx_data` into the shifter, with a `tx_taken` pulse. That byte is then sent MSB first.
- R9: When the master acknowledges a transmitted byte (SDA low in its acknowledge slot), `tx_data` is copied again, with a `tx_taken` pulse, and sent next.
- R10: When the master does not acknowledge a transmitted byte, the slave releases SDA and loads nothing more until a START or STOP.
- R11: A STOP, or a repeated START, returns the slave to its idle or address state and clears `matched` and `slave_read`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| own_addr | input | 7 | Programmed slave address |
| partial_mode | input | 1 | 1 compares only the upper 4 address bits |
| nack_cfg | input | 1 | Acknowledge level for received data: 1 sends NoAck |
| tx_data | input | 8 | Next byte to transmit |
| tx_taken | output | 1 | Pulse: `tx_data` copied into the shifter |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | Pulse: `rx_data` holds a new byte |
| matched | output | 1 | Address matched in the current transfer |
| slave_read | output | 1 | Direction of the matched transfer (1 = slave transmits) |

## Verification
Each bus event reaches the slave's state three clock cycles after the line moves: two synchroniser flops, then the edge-detect register. `sda_oe`, `rx_valid`, `tx_taken`, `matched` and `slave_read` therefore change about three to four cycles after the SCL fall that ends a byte or an acknowledge slot. The bench drives a bus master in which each bit phase lasts five clock cycles. The master changes SDA only five cycles after an SCL fall, and it samples SDA five cycles after an SCL rise, so every slave response has settled before it is read. Flags are checked only after a whole byte or a STOP has finished. An exhaustive sweep of all 128 addresses, in both compare modes, checks the acknowledge bit and the match flag against a compare that the bench computes itself.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_WAIT
  } slv_state_t;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int QW = SYNC_STAGES + 1;

  logic [QW-1:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[QW-2:0], scl_i};
      sda_q <= {sda_q[QW-2:0], sda_i};
    end
  end

  assign scl_s = scl_q[QW-2];
  assign scl_p = scl_q[QW-1];
  assign sda_s = sda_q[QW-2];
  assign sda_p = sda_q[QW-1];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
  parameter int ADDR_W = 7,
  parameter int PART_W = 4
) (
  input  logic [ADDR_W:0]   addr_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              partial_mode,
  output logic              hit,
  output logic              rw
);
  logic full_hit, part_hit;

  assign full_hit = (addr_byte[ADDR_W:1] == own_addr);
  assign part_hit = (addr_byte[ADDR_W -: PART_W] == own_addr[ADDR_W-1 -: PART_W]);
  assign hit      = partial_mode ? part_hit : full_hit;
  assign rw       = addr_byte[0];
endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
  import i2c_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              hit,
  input  logic              rw,
  input  logic              nack_cfg,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] shreg,
  output logic              sda_oe,
  output logic              tx_taken,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              matched,
  output logic              slave_read
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] FULL = CW'(DATA_W);

  slv_state_t    state;
  logic [CW-1:0] cnt;
  logic          mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      cnt        <= '0;
      mack       <= 1'b0;
      matched    <= 1'b0;
      slave_read <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      tx_taken   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_taken <= 1'b0;
      if (stop_det) begin
        state      <= ST_IDLE;
        matched    <= 1'b0;
        slave_read <= 1'b0;
      end else if (start_det) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        matched    <= 1'b0;
        slave_read <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (hit) begin
                matched    <= 1'b1;
                slave_read <= rw;
                state      <= ST_AACK;
                if (rw) begin
                  shreg    <= tx_data;
                  tx_taken <= 1'b1;
                end
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt   <= '0;
            state <= slave_read ? ST_TX : ST_RX;
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              rx_data  <= shreg;
              rx_valid <= 1'b1;
              state    <= ST_RACK;
            end
          end
          ST_RACK: if (scl_fall) begin
            cnt   <= '0;
            state <= ST_RX;
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) state <= ST_TACK;
              else shreg <= {shreg[DATA_W-2:0], 1'b1};
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                shreg    <= tx_data;
                tx_taken <= 1'b1;
                cnt      <= '0;
                state    <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      ST_AACK: sda_oe = 1'b1;
      ST_RACK: sda_oe = ~nack_cfg;
      ST_TX:   sda_oe = ~shreg[DATA_W-1];
      default: sda_oe = 1'b0;
    endcase
  end

  a_r1_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state == ST_ADDR && cnt == '0));
  a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!matched && !slave_read && state == ST_IDLE));
  a_r5_no_drive_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
    !matched |-> !sda_oe);
  a_r6_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r8_load_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |-> (matched && slave_read));
  a_r10_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe);
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave #(
  parameter int ADDR_W      = 7,
  parameter int PART_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              partial_mode,
  input  logic              nack_cfg,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_taken,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              matched,
  output logic              slave_read
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic hit, rw;
  logic [DATA_W-1:0] shreg;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_addr_cmp #(.ADDR_W(ADDR_W), .PART_W(PART_W)) u_cmp (
    .addr_byte(shreg[ADDR_W:0]), .own_addr(own_addr),
    .partial_mode(partial_mode), .hit(hit), .rw(rw)
  );

  i2c_slave_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .hit(hit), .rw(rw), .nack_cfg(nack_cfg), .tx_data(tx_data),
    .shreg(shreg), .sda_oe(sda_oe), .tx_taken(tx_taken),
    .rx_data(rx_data), .rx_valid(rx_valid), .matched(matched),
    .slave_read(slave_read)
  );

  a_r4_match_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matched) |-> $past(hit));
endmodule

// File: tb/sim_i2c_addr_slave.sv
module sim_i2c_addr_slave;
  localparam int Q = 5;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, tx_taken, rx_valid, matched, slave_read;
  logic [7:0] rx_data, tx_data;
  logic [6:0] own_addr;
  logic partial_mode, nack_cfg;
  int checks = 0, errors = 0;
  int rx_cnt = 0, tx_cnt = 0;
  logic [7:0] rx_last = '0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_addr_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .own_addr(own_addr), .partial_mode(partial_mode), .nack_cfg(nack_cfg),
    .tx_data(tx_data), .tx_taken(tx_taken), .rx_data(rx_data),
    .rx_valid(rx_valid), .matched(matched), .slave_read(slave_read)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
    if (tx_taken) tx_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q);
    r = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack_n);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, ack_n);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); d[i] = r; end
    clk_bit(nack, r);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ackn;
    logic [7:0] d;
    int n0;
    own_addr = OWN; partial_mode = 1'b0; nack_cfg = 1'b0; tx_data = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);
    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 matched", matched, 0);
    chk("R1 rx_valid", rx_valid, 0);

    // R2/R3/R5 exhaustive address sweep in both modes
    for (int pm = 0; pm < 2; pm++) begin
      partial_mode = pm[0];
      for (int a = 0; a < 128; a++) begin
        logic exp_hit;
        logic [6:0] av;
        av = a[6:0];
        exp_hit = pm[0] ? (av[6:3] == OWN[6:3]) : (av == OWN);
        bus_start;
        write_byte({av, 1'b0}, ackn);
        chk(pm[0] ? "R3 ack" : "R2 ack", ackn, !exp_hit);
        chk("R5 matched", matched, exp_hit);
        bus_stop;
        chk("R11 matched after stop", matched, 0);
      end
    end
    partial_mode = 1'b0;

    // R4 R6 R7 write transfer with Ack
    bus_start;
    write_byte({OWN, 1'b0}, ackn);
    chk("R4 matched", matched, 1);
    chk("R4 slave_read", slave_read, 0);
    n0 = rx_cnt;
    write_byte(8'hA5, ackn);
    chk("R6 rx_data", rx_last, 8'hA5);
    chk("R6 rx count", rx_cnt - n0, 1);
    chk("R7 ack when nack_cfg=0", ackn, 0);
    nack_cfg = 1'b1;
    write_byte(8'h3C, ackn);
    chk("R6 rx_data second", rx_last, 8'h3C);
    chk("R7 noack when nack_cfg=1", ackn, 1);
    nack_cfg = 1'b0;
    bus_stop;

    // R5 mismatch: data ignored
    bus_start;
    write_byte({OWN ^ 7'h40, 1'b0}, ackn);
    n0 = rx_cnt;
    write_byte(8'h00, ackn);
    chk("R5 ignored data no ack", ackn, 1);
    chk("R5 ignored data no rx", rx_cnt - n0, 0);
    bus_stop;

    // R8 R9 R10 read transfer
    tx_data = 8'hC3;
    n0 = tx_cnt;
    bus_start;
    write_byte({OWN, 1'b1}, ackn);
    chk("R8 address ack", ackn, 0);
    chk("R4 slave_read read", slave_read, 1);
    chk("R8 tx_taken on match", tx_cnt - n0, 1);
    tx_data = 8'h96;
    read_byte(1'b0, d);
    chk("R8 first byte", d, 8'hC3);
    chk("R9 reload after ack", tx_cnt - n0, 2);
    tx_data = 8'h11;
    read_byte(1'b1, d);
    chk("R9 second byte", d, 8'h96);
    read_byte(1'b1, d);
    chk("R10 released after noack", d, 8'hFF);
    chk("R10 no further load", tx_cnt - n0, 2);
    bus_stop;
    chk("R11 slave_read cleared", slave_read, 0);

    // R11 repeated start mid-transfer
    bus_start;
    write_byte({OWN, 1'b0}, ackn);
    write_byte(8'h7E, ackn);
    bus_start;
    chk("R11 matched cleared by restart", matched, 0);
    write_byte({OWN, 1'b1}, ackn);
    chk("R11 restart readdress ack", ackn, 0);
    chk("R11 restart direction", slave_read, 1);
    read_byte(1'b1, d);
    chk("R8 byte after restart", d, 8'h11);
    bus_stop;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule